// File: doc/BRIEF.md
# ATA PIO Register Cycle Sequencer

This block runs one register read or register write on a parallel ATA device port in programmed-I/O mode. The host side presents a request that carries a direction, a 5-bit register index and 16-bit write data. The block then steps the device pins through three phases:

- **Setup:** address and chip selects are driven while both strobes stay high.
- **Active:** the read or write strobe is held low.
- **Recovery:** address is held while both strobes are high.

The block then pulses `done` and presents the read data.

The length of each phase, in clock cycles, comes from a per-mode timing table. The table is computed at elaboration from nanosecond figures and the clock period. The active phase is stretched for as long as the device holds IORDY low, with a timeout that ends the wait. Read data is captured on the same clock edge that raises the read strobe, because the device may release the bus within a few nanoseconds of that edge.

The transfer mode (0 to 4) lives in a small mode register. It comes out of reset at mode 4 and can be lowered at run time for slower devices. Each cycle uses the mode that was in force when its request was accepted.

Top module: `pio_cycle_seq`

## Requirements
- R1: While reset is applied and after it:
  - both strobes are high, `ata_cs_n` is 2'b11 and `ata_da` is 0;
  - `ata_dd_oe`, `busy`, `done` and `err` are 0, and `rdata` is 0;
  - the mode register holds 4.
- R2: Setup phase.
  - On the edge that accepts a request, address and chip selects take their cycle values and `busy` rises.
  - Both strobes stay high for S cycles, where S = ceil(setup_ns / CLK_NS), minimum 1.
  - The setup figures in ns for modes 0..4 are 70, 50, 30, 30, 25.
- R3: Active phase.
  - Exactly one strobe is low: `ata_dior_n` for a read, `ata_diow_n` for a write.
  - It stays low for at least A = ceil(active_ns / CLK_NS) cycles. The active figures in ns for modes 0..4 are 165, 125, 100, 80, 70.
  - After that it stays low while the IORDY level, seen through a 2-flop synchronizer, is low.
  - The strobe is raised on the first edge at or after the minimum on which the synchronized level is high.
- R4: Recovery phase.
  - After the strobe rises, address and chip selects are held for R cycles, where R = ceil(recovery_ns / CLK_NS). The recovery figures in ns for modes 0..4 are 365, 208, 110, 70, 25.
  - On the next edge the lines return to the idle values of R1.
- R5: Read data capture.
  - For a read, `ata_dd_i` is captured on the edge that raises `ata_dior_n`.
  - It is shown on `rdata` from that edge until the next read captures.
  - Writes and rejected requests leave `rdata` unchanged.
- R6: Index mapping. Register index bits [2:0] drive `ata_da`, and bits [4:3] drive `ata_cs_n[1:0]` unchanged.
- R7: Mode register.
  - A `mode_wr` pulse with `mode_in` 0..4 loads the mode register.
  - A value of 5..7 is ignored.
  - A cycle uses the mode held at its acceptance edge.
- R8: Write data bus. For a write, `ata_dd_oe` is 1 and `ata_dd_o` equals the write data from the acceptance edge to the end of recovery. At all other times `ata_dd_oe` is 0.
- R9: Handshake.
  - `busy` is high from acceptance to the end of recovery.
  - `done` is high for exactly one cycle, the first cycle with the lines idle.
  - Requests presented while `busy` is high are ignored.
- R10: Timeout. If the synchronized IORDY is still low after TIMEOUT_CYC low samples past the minimum active time, the strobe is raised on the next sample and the cycle completes normally, with `err` high alongside `done`.
- R11: Rejected request. A request with both `req_rd` and `req_wr` set drives no strobe and no address. It pulses `done` and `err` together for one cycle, on the edge after it is presented.
- R12: A request with neither direction bit set is ignored: no `busy`, no `done`, and no pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load the transfer mode register |
| mode_in | input | 3 | New transfer mode (0..4 accepted) |
| req_valid | input | 1 | Request strobe, taken only while busy is low |
| req_rd | input | 1 | Request is a register read |
| req_wr | input | 1 | Request is a register write |
| req_reg | input | 5 | Register index: [2:0] address, [4:3] chip selects |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with timeout or rejection, valid with done |
| rdata | output | DW | Last captured read data |
| ata_da | output | 3 | Device address lines |
| ata_cs_n | output | 2 | Device chip selects, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_o | output | DW | Data bus drive value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_i | input | DW | Data bus input |
| ata_iordy | input | 1 | Device ready, asynchronous |

## Verification
Every output is registered, so each pin change is due one edge after the state that causes it. Examples:

- Address appears the cycle after the request is sampled.
- The strobe falls S edges after acceptance.
- IORDY acts two edges after it changes, because of the synchronizer.
- `done` follows the R-th recovery edge by one.

The bench model advances on each rising edge using the same sampled inputs as the design, and the bench compares at the falling edge. This way every expected value is read half a cycle after the edge that produces it. Directed checks after each `done` confirm the captured read word and the error flag.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  localparam int PIO_CNT_W = 8;
  localparam int PIO_NUM_MODES = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_RECOV  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [PIO_CNT_W-1:0] setup;
    logic [PIO_CNT_W-1:0] active;
    logic [PIO_CNT_W-1:0] recov;
  } phase_cycles_t;

  // Round a nanosecond figure up to whole clocks, never below one clock.
  function automatic logic [PIO_CNT_W-1:0] ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return PIO_CNT_W'(c);
  endfunction

endpackage

// File: rtl/pio_iordy_sync.sv
module pio_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pio_mode_ctl.sv
module pio_mode_ctl
  import pio_seq_pkg::*;
#(
  parameter int CLK_NS = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic [2:0]    mode_in,
  output phase_cycles_t timing_o
);
  localparam int MAX_MODE = PIO_NUM_MODES - 1;
  localparam int SETUP_NS  [PIO_NUM_MODES] = '{70, 50, 30, 30, 25};
  localparam int ACTIVE_NS [PIO_NUM_MODES] = '{165, 125, 100, 80, 70};
  localparam int RECOV_NS  [PIO_NUM_MODES] = '{365, 208, 110, 70, 25};

  logic [2:0]    mode_q;
  phase_cycles_t table_w [PIO_NUM_MODES];

  for (genvar m = 0; m < PIO_NUM_MODES; m++) begin : g_mode
    assign table_w[m].setup  = ns_to_cycles(SETUP_NS[m], CLK_NS);
    assign table_w[m].active = ns_to_cycles(ACTIVE_NS[m], CLK_NS);
    assign table_w[m].recov  = ns_to_cycles(RECOV_NS[m], CLK_NS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 3'(MAX_MODE);
    end else if (mode_wr && (mode_in <= 3'(MAX_MODE))) begin
      mode_q <= mode_in;
    end
  end

  always_comb begin
    timing_o = table_w[0];
    for (int i = 0; i < PIO_NUM_MODES; i++) begin
      if (mode_q == 3'(i)) timing_o = table_w[i];
    end
  end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int TIMEOUT_CYC = 16,
  parameter int DW          = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic [2:0]    mode_in,
  input  logic          req_valid,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [4:0]    req_reg,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [2:0]    ata_da,
  output logic [1:0]    ata_cs_n,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic [DW-1:0] ata_dd_o,
  output logic          ata_dd_oe,
  input  logic [DW-1:0] ata_dd_i,
  input  logic          ata_iordy
);
  localparam int WAIT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [WAIT_W-1:0] WAIT_LIMIT = WAIT_W'(TIMEOUT_CYC);

  phase_cycles_t        mode_timing;
  phase_cycles_t        cyc_timing_q;
  seq_state_e           state_q;
  logic [PIO_CNT_W-1:0] cnt_q;
  logic [WAIT_W-1:0]    wait_q;
  logic                 is_read_q;
  logic                 late_q;
  logic                 iordy_s;

  pio_iordy_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ata_iordy),
    .sync_out (iordy_s)
  );

  pio_mode_ctl #(.CLK_NS(CLK_NS)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_wr  (mode_wr),
    .mode_in  (mode_in),
    .timing_o (mode_timing)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      wait_q       <= '0;
      is_read_q    <= 1'b0;
      late_q       <= 1'b0;
      cyc_timing_q <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      rdata        <= '0;
      ata_da       <= '0;
      ata_cs_n     <= 2'b11;
      ata_dior_n   <= 1'b1;
      ata_diow_n   <= 1'b1;
      ata_dd_o     <= '0;
      ata_dd_oe    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_rd && req_wr) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else if (req_rd || req_wr) begin
              state_q      <= ST_SETUP;
              cyc_timing_q <= mode_timing;
              cnt_q        <= mode_timing.setup - 1'b1;
              ata_da       <= req_reg[2:0];
              ata_cs_n     <= req_reg[4:3];
              ata_dd_o     <= req_wdata;
              ata_dd_oe    <= req_wr;
              is_read_q    <= req_rd;
              late_q       <= 1'b0;
              busy         <= 1'b1;
            end
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= cyc_timing_q.active - 1'b1;
            wait_q  <= '0;
            if (is_read_q) ata_dior_n <= 1'b0;
            else           ata_diow_n <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (iordy_s || (wait_q == WAIT_LIMIT)) begin
            state_q    <= ST_RECOV;
            cnt_q      <= cyc_timing_q.recov - 1'b1;
            ata_dior_n <= 1'b1;
            ata_diow_n <= 1'b1;
            late_q     <= ~iordy_s;
            if (is_read_q) rdata <= ata_dd_i;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_RECOV: begin
          if (cnt_q == '0) begin
            state_q   <= ST_IDLE;
            ata_da    <= '0;
            ata_cs_n  <= 2'b11;
            ata_dd_oe <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b1;
            err       <= late_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [2:0] da,
  input logic [1:0] cs_n,
  input logic       dior_n,
  input logic       diow_n,
  input logic       dd_oe
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n)); // R3

  AST_STROBE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> busy); // R2

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n == 2'b11 && da == 3'd0 && dior_n && diow_n && !dd_oe)); // R4

  AST_ADDR_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(dior_n) || $fell(diow_n)) |-> ($stable(da) && $stable(cs_n))); // R2

  AST_ADDR_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(dior_n) || $rose(diow_n)) |-> ($stable(da) && $stable(cs_n))); // R4

  AST_BUS_NOT_DRIVEN_ON_READ: assert property (@(posedge clk) disable iff (rst)
    dd_oe |-> dior_n); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !busy)); // R10
endmodule

bind pio_cycle_seq pio_cycle_seq_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .da     (ata_da),
  .cs_n   (ata_cs_n),
  .dior_n (ata_dior_n),
  .diow_n (ata_diow_n),
  .dd_oe  (ata_dd_oe)
);

// File: tb/pio_cycle_seq_tb.sv
module pio_cycle_seq_tb;
  localparam int CLK_NS = 20;
  localparam int TMO    = 16;
  localparam int DW     = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 1'b0;
  logic [2:0] mode_in = 3'd0;
  logic req_valid = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
  logic [4:0] req_reg = 5'd0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done, err;
  logic [DW-1:0] rdata, ata_dd_o, ata_dd_i;
  logic [2:0] ata_da;
  logic [1:0] ata_cs_n;
  logic ata_dior_n, ata_diow_n, ata_dd_oe;
  logic ata_iordy = 1'b1;

  always #10 clk = ~clk;

  // Device model: a word tied to the selected register while read strobe is low.
  assign ata_dd_i = !ata_dior_n ? (16'hC300 ^ {11'd0, ata_cs_n, ata_da}) : 16'hDEAD;

  pio_cycle_seq #(.CLK_NS(CLK_NS), .TIMEOUT_CYC(TMO), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
    .req_valid(req_valid), .req_rd(req_rd), .req_wr(req_wr),
    .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .ata_da(ata_da), .ata_cs_n(ata_cs_n), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dd_o(ata_dd_o), .ata_dd_oe(ata_dd_oe),
    .ata_dd_i(ata_dd_i), .ata_iordy(ata_iordy)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int up(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int t_setup(input int m);
    int v [5] = '{70, 50, 30, 30, 25};
    return up(v[m]);
  endfunction
  function automatic int t_active(input int m);
    int v [5] = '{165, 125, 100, 80, 70};
    return up(v[m]);
  endfunction
  function automatic int t_recov(input int m);
    int v [5] = '{365, 208, 110, 70, 25};
    return up(v[m]);
  endfunction

  // Behavioural reference model, advanced on each rising edge.
  int m_phase, m_el, m_low, m_mode, m_S, m_A, m_R;
  bit m_rd, m_late, m_q1, m_q2, started;
  logic e_dior, e_diow, e_oe, e_busy, e_done, e_err;
  logic [2:0] e_da;
  logic [1:0] e_cs;
  logic [DW-1:0] e_ddo, e_rdata;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      m_phase = 0; m_el = 0; m_low = 0; m_mode = 4; m_rd = 0; m_late = 0;
      m_q1 = 0; m_q2 = 0;
      e_dior = 1; e_diow = 1; e_oe = 0; e_busy = 0; e_done = 0; e_err = 0;
      e_da = 0; e_cs = 2'b11; e_ddo = 0; e_rdata = 0;
    end else begin
      e_done = 0; e_err = 0;
      case (m_phase)
        0: if (req_valid) begin
          if (req_rd && req_wr) begin
            e_done = 1; e_err = 1;
          end else if (req_rd || req_wr) begin
            m_phase = 1; m_el = 1; m_late = 0;
            m_S = t_setup(m_mode); m_A = t_active(m_mode); m_R = t_recov(m_mode);
            e_da = req_reg[2:0]; e_cs = req_reg[4:3];
            e_oe = req_wr; e_ddo = req_wdata; m_rd = req_rd; e_busy = 1;
          end
        end
        1: if (m_el == m_S) begin
          m_phase = 2; m_el = 1; m_low = 0;
          if (m_rd) e_dior = 0; else e_diow = 0;
        end else m_el++;
        2: if (m_el < m_A) m_el++;
           else if (m_q2 || m_low == TMO) begin
             m_late = !m_q2;
             if (m_rd) e_rdata = ata_dd_i;
             e_dior = 1; e_diow = 1; m_phase = 3; m_el = 1;
           end else m_low++;
        default: if (m_el == m_R) begin
          m_phase = 0; e_da = 0; e_cs = 2'b11; e_oe = 0; e_busy = 0;
          e_done = 1; e_err = m_late;
        end else m_el++;
      endcase
      if (mode_wr && mode_in <= 3'd4) m_mode = int'(mode_in);
      m_q2 = m_q1; m_q1 = ata_iordy;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(ata_dior_n === e_dior && ata_diow_n === e_diow, "R3 strobes",
          {ata_dior_n, ata_diow_n}, {e_dior, e_diow});
      chk(ata_da === e_da && ata_cs_n === e_cs, "R6 address/chip selects",
          {ata_cs_n, ata_da}, {e_cs, e_da});
      chk(ata_dd_oe === e_oe && (!e_oe || ata_dd_o === e_ddo), "R8 data drive",
          {ata_dd_oe, ata_dd_o}, {e_oe, e_ddo});
      chk(busy === e_busy && done === e_done, "R9 busy/done",
          {busy, done}, {e_busy, e_done});
      chk(err === e_err, "R10 err", err, e_err);
      chk(rdata === e_rdata, "R5 rdata", rdata, e_rdata);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode_wr = 1; mode_in = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic xfer(input bit rd, input logic [4:0] r, input logic [15:0] wd,
                      input int low_cyc, input bit exp_err);
    @(negedge clk);
    req_valid = 1; req_rd = rd; req_wr = !rd; req_reg = r; req_wdata = wd;
    if (low_cyc > 0) ata_iordy = 0;
    @(negedge clk);
    req_valid = 0;
    // R9: a request while busy is ignored
    req_valid = 1; req_rd = 1; req_wr = 0; req_reg = 5'h1F;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      if (i + 2 >= low_cyc) ata_iordy = 1;
      @(negedge clk);
    end
    ata_iordy = 1;
    chk(done === 1'b1, "R9 done reached", done, 1);
    chk(err === exp_err, "R10 error flag on completion", err, exp_err);
    if (rd) chk(rdata === (16'hC300 ^ {11'd0, r}), "R5 captured read word",
                rdata, 16'hC300 ^ {11'd0, r});
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ata_dior_n && ata_diow_n && ata_cs_n == 2'b11 && !busy && !ata_dd_oe,
        "R1 reset state", {ata_dior_n, ata_diow_n, ata_cs_n, busy}, 5'b11110);
    rst = 0;
    repeat (3) @(negedge clk);
    // R1 R7: default mode 4 timing
    xfer(1, 5'b10_110, 16'h0, 0, 0);
    xfer(0, 5'b01_011, 16'h5AA5, 0, 0);
    // R7: each mode
    for (int m = 0; m < 4; m++) begin
      set_mode(3'(m));
      xfer(1, 5'(5'h10 + m), 16'h0, 0, 0);
      xfer(0, 5'(5'h08 + m), 16'(16'h1234 + m), 0, 0);
    end
    // R7: out-of-range value ignored (mode stays 3)
    set_mode(3'd6);
    xfer(1, 5'b10_111, 16'h0, 0, 0);
    set_mode(3'd4);
    // R3: IORDY stretch
    xfer(1, 5'b10_001, 16'h0, 12, 0);
    xfer(0, 5'b10_010, 16'hBEEF, 9, 0);
    // R10: timeout
    xfer(1, 5'b10_100, 16'h0, 60, 1);
    xfer(0, 5'b01_110, 16'hCAFE, 60, 1);
    // R11: both direction bits
    @(negedge clk); req_valid = 1; req_rd = 1; req_wr = 1; req_reg = 5'h12;
    @(negedge clk); req_valid = 0; req_rd = 0; req_wr = 0;
    chk(done && err && ata_dior_n && ata_diow_n && ata_cs_n == 2'b11,
        "R11 rejected request", {done, err, ata_dior_n, ata_diow_n}, 4'b1111);
    // R12: no direction bit
    @(negedge clk); req_valid = 1; req_reg = 5'h11;
    @(negedge clk); req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy && !done && ata_cs_n == 2'b11, "R12 empty request ignored",
          {busy, done, ata_cs_n}, 4'b0011);
      @(negedge clk);
    end
    // R2 R4: back-to-back in mode 0
    set_mode(3'd0);
    xfer(0, 5'b10_000, 16'h0F0F, 0, 0);
    xfer(1, 5'b10_000, 16'h0, 0, 0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule